// File: doc/BRIEF.md
# Debug Link Sync Pulse Sequencer

This block sits on the host side of a single-wire debug link whose line is open-drain and bidirectional. On request it runs the speed-discovery handshake. It holds the line low long enough that even the slowest possible target clock sees the request. It then gives a brief active-high kick so the line rises quickly. It then lets go of the line completely and waits for the target to answer with a low pulse. The width of that pulse, counted in host clocks, tells the host how fast the target's communication clock runs. The host uses that width to set up later bit transfers.

No command byte is involved. The line is only driven low, then driven high, then released. The block produces two drive enables for the pad: one that pulls the line low and one that drives it high. When neither is asserted, the pad is left floating. The sampled line level comes back in through `pin_i`. A measurement ends with a one-cycle `done_o` and a latched width. When the target stays silent or holds the line low too long, the measurement ends with a one-cycle `timeout_o` instead.

Top module: `dsync_host`

## Requirements
- R1: After reset, `drv_low_o`, `drv_high_o`, `done_o` and `timeout_o` are 0 and `width_o` is 0.
- R2: A start request seen at a clock edge while idle makes `drv_low_o` high from the next cycle. It stays high for exactly LOW_CYCLES consecutive cycles. The default is 8192, which is 128 periods of a clock 64 times slower than the host clock.
- R3: Right after the low phase, `drv_high_o` is high for exactly KICK_CYCLES cycles. After that, both drive enables are 0 until the sequence ends.
- R4: `drv_low_o` and `drv_high_o` are never 1 in the same cycle.
- R5: Release begins at the edge where `drv_high_o` drops. A falling edge on `pin_i`, meaning a 1 sample followed by a 0 sample, must reach the k-th clock edge after release with 1 ≤ k ≤ LISTEN_CYCLES to be accepted. If no falling edge arrives by edge LISTEN_CYCLES, `timeout_o` pulses and the block goes idle.
- R6: For an accepted response, `width_o` equals the number of consecutive clock edges at which `pin_i` is sampled 0. `done_o` pulses for one cycle, in the cycle after the first edge that samples `pin_i` as 1. `width_o` keeps its value until the next `done_o`.
- R7: If `pin_i` is still 0 at the edge after PULSE_MAX low samples, `timeout_o` pulses instead of `done_o`. The largest width that can be measured is PULSE_MAX.
- R8: A start request that arrives while a sequence is running is ignored. It neither stretches the running sequence nor leaves a sequence pending for after it ends.
- R9: Each sequence ends with exactly one pulse of either `done_o` or `timeout_o`, never both. A start request after that begins a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to run one sync sequence |
| pin_i | input | 1 | Sampled level of the debug line |
| drv_low_o | output | 1 | Pad enable that pulls the line low |
| drv_high_o | output | 1 | Pad enable that drives the line high |
| width_o | output | $clog2(PULSE_MAX+1) | Latched response low-pulse width in host clocks |
| done_o | output | 1 | One-cycle pulse when a width has been measured |
| timeout_o | output | 1 | One-cycle pulse when the response was absent or too long |

## Verification
The bench builds the block with LOW_CYCLES=16, KICK_CYCLES=2, LISTEN_CYCLES=6 and PULSE_MAX=10. At these sizes every phase is short enough to be counted cycle by cycle. The bench sweeps every response delay from 0 to LISTEN_CYCLES together with every pulse width from 1 to PULSE_MAX+1. That covers both timeout edges and the largest width the block can measure. In alternate runs a second start request is injected during the low phase, so it can be seen that the request is ignored.

// File: rtl/dsync_pkg.sv
package dsync_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_KICK,
    ST_LISTEN,
    ST_MEAS
  } dsync_state_e;
endpackage

// File: rtl/dsync_phase_timer.sv
module dsync_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt_o <= '0;
    else            cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/dsync_edge_meter.sv
module dsync_edge_meter #(
  parameter int PULSE_MAX = 10,
  parameter int CW        = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pin_i,
  input  logic          arm,
  input  logic          measuring,
  output logic          fall_o,
  output logic          low_o,
  output logic          full_o,
  output logic [CW-1:0] cnt_o
);
  logic pin_d;

  always_ff @(posedge clk) begin
    if (rst) pin_d <= 1'b1;
    else     pin_d <= pin_i;
  end

  assign fall_o = pin_d & ~pin_i;
  assign low_o  = ~pin_i;
  assign full_o = (cnt_o == CW'(PULSE_MAX));

  always_ff @(posedge clk) begin
    if (rst)                                cnt_o <= '0;
    else if (arm && fall_o)                 cnt_o <= CW'(1);
    else if (measuring && low_o && !full_o) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/dsync_host.sv
module dsync_host #(
  parameter int LOW_CYCLES    = 8192,
  parameter int KICK_CYCLES   = 1,
  parameter int LISTEN_CYCLES = 4096,
  parameter int PULSE_MAX     = 1024
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start_i,
  input  logic                           pin_i,
  output logic                           drv_low_o,
  output logic                           drv_high_o,
  output logic [$clog2(PULSE_MAX+1)-1:0] width_o,
  output logic                           done_o,
  output logic                           timeout_o
);
  import dsync_pkg::*;

  localparam int CW     = $clog2(PULSE_MAX + 1);
  localparam int MAX_A  = (LOW_CYCLES > KICK_CYCLES) ? LOW_CYCLES : KICK_CYCLES;
  localparam int MAX_PH = (MAX_A > LISTEN_CYCLES) ? MAX_A : LISTEN_CYCLES;
  localparam int TW     = $clog2(MAX_PH + 1);

  dsync_state_e st, st_nx;
  logic [TW-1:0] tcnt, tlim;
  logic          t_last, t_clr;
  logic          fall, low, full;
  logic [CW-1:0] mcnt;

  dsync_phase_timer #(.W(TW)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clr   (t_clr),
    .cnt_o (tcnt)
  );

  dsync_edge_meter #(.PULSE_MAX(PULSE_MAX), .CW(CW)) u_meter (
    .clk       (clk),
    .rst       (rst),
    .pin_i     (pin_i),
    .arm       (st == ST_LISTEN),
    .measuring (st == ST_MEAS),
    .fall_o    (fall),
    .low_o     (low),
    .full_o    (full),
    .cnt_o     (mcnt)
  );

  always_comb begin
    case (st)
      ST_LOW:    tlim = TW'(LOW_CYCLES - 1);
      ST_KICK:   tlim = TW'(KICK_CYCLES - 1);
      ST_LISTEN: tlim = TW'(LISTEN_CYCLES - 1);
      default:   tlim = '0;
    endcase
  end
  assign t_last = (tcnt == tlim);

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:   if (start_i) st_nx = ST_LOW;
      ST_LOW:    if (t_last)  st_nx = ST_KICK;
      ST_KICK:   if (t_last)  st_nx = ST_LISTEN;
      ST_LISTEN: if (fall)    st_nx = ST_MEAS;
                 else if (t_last) st_nx = ST_IDLE;
      ST_MEAS:   if (!low || full) st_nx = ST_IDLE;
      default:   st_nx = ST_IDLE;
    endcase
  end
  assign t_clr = (st_nx != st) || (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      drv_low_o  <= 1'b0;
      drv_high_o <= 1'b0;
      done_o     <= 1'b0;
      timeout_o  <= 1'b0;
      width_o    <= '0;
    end else begin
      st         <= st_nx;
      drv_low_o  <= (st_nx == ST_LOW);
      drv_high_o <= (st_nx == ST_KICK);
      done_o     <= 1'b0;
      timeout_o  <= 1'b0;
      if (st == ST_LISTEN && !fall && t_last) timeout_o <= 1'b1;
      if (st == ST_MEAS) begin
        if (!low) begin
          done_o  <= 1'b1;
          width_o <= mcnt;
        end else if (full) begin
          timeout_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dsync_host_chk.sv
module dsync_host_chk #(
  parameter int LOW_CYCLES    = 8192,
  parameter int KICK_CYCLES   = 1,
  parameter int LISTEN_CYCLES = 4096,
  parameter int PULSE_MAX     = 1024
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           drv_low_o,
  input logic                           drv_high_o,
  input logic [$clog2(PULSE_MAX+1)-1:0] width_o,
  input logic                           done_o,
  input logic                           timeout_o
);
  localparam int LW = $clog2(LOW_CYCLES + 2);
  localparam int KW = $clog2(KICK_CYCLES + 2);

  logic [LW-1:0] low_run;
  logic [KW-1:0] kick_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run  <= '0;
      kick_run <= '0;
    end else begin
      low_run  <= drv_low_o  ? low_run + 1'b1  : '0;
      kick_run <= drv_high_o ? kick_run + 1'b1 : '0;
    end
  end

  a_r4_no_contention: assert property (@(posedge clk) disable iff (rst)
    !(drv_low_o && drv_high_o));

  a_r2_low_length: assert property (@(posedge clk) disable iff (rst)
    $fell(drv_low_o) |-> (low_run == LW'(LOW_CYCLES)));

  a_r3_kick_length: assert property (@(posedge clk) disable iff (rst)
    $fell(drv_high_o) |-> (kick_run == KW'(KICK_CYCLES)));

  a_r3_kick_follows_low: assert property (@(posedge clk) disable iff (rst)
    drv_low_o |=> (drv_low_o || drv_high_o));

  a_r3_release_after_kick: assert property (@(posedge clk) disable iff (rst)
    $fell(drv_high_o) |-> !drv_low_o);

  a_r9_single_outcome: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done_o, timeout_o}));

  a_r9_outcome_pulse: assert property (@(posedge clk) disable iff (rst)
    (done_o || timeout_o) |=> !(done_o || timeout_o));

  a_r6_width_range: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (width_o != '0 && width_o <= PULSE_MAX));

  a_r8_no_drive_at_outcome: assert property (@(posedge clk) disable iff (rst)
    (done_o || timeout_o) |-> !(drv_low_o || drv_high_o));
endmodule

bind dsync_host dsync_host_chk #(
  .LOW_CYCLES    (LOW_CYCLES),
  .KICK_CYCLES   (KICK_CYCLES),
  .LISTEN_CYCLES (LISTEN_CYCLES),
  .PULSE_MAX     (PULSE_MAX)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .drv_low_o  (drv_low_o),
  .drv_high_o (drv_high_o),
  .width_o    (width_o),
  .done_o     (done_o),
  .timeout_o  (timeout_o)
);

// File: tb/dsync_host_bench.sv
`timescale 1ns/1ps
module dsync_host_bench;
  localparam int LOWC = 16;
  localparam int KICK = 2;
  localparam int LIST = 6;
  localparam int PMAX = 10;
  localparam int CW   = $clog2(PMAX + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic pin = 1'b1;
  logic drv_low, drv_high, done, tmo;
  logic [CW-1:0] width;

  int checks = 0;
  int failures = 0;
  int ndone, nto, overlap, lastw;

  always #2.5 clk = ~clk;

  dsync_host #(
    .LOW_CYCLES(LOWC), .KICK_CYCLES(KICK),
    .LISTEN_CYCLES(LIST), .PULSE_MAX(PMAX)
  ) u_dsync_host (
    .clk(clk), .rst(rst), .start_i(start), .pin_i(pin),
    .drv_low_o(drv_low), .drv_high_o(drv_high), .width_o(width),
    .done_o(done), .timeout_o(tmo)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (done) begin ndone++; lastw = int'(width); end
    if (tmo) nto++;
    if (drv_low && drv_high) overlap++;
  endtask

  task automatic run_seq(input int d, input int n, input bit poke);
    int lowcnt, hicnt, relbad;
    bit exp_done;
    ndone = 0; nto = 0; overlap = 0; lastw = -1;
    lowcnt = 0; hicnt = 0; relbad = 0;
    exp_done = (d < LIST) && (n <= PMAX);
    start = 1'b1;
    step();
    start = 1'b0;
    while (drv_low && lowcnt < 1000) begin
      lowcnt++;
      start = poke && (lowcnt == 3);
      step();
    end
    start = 1'b0;
    chk(lowcnt == LOWC, poke ? "R8 low phase with extra start" : "R2 low phase length", lowcnt, LOWC);
    while (drv_high && hicnt < 1000) begin
      hicnt++;
      step();
    end
    chk(hicnt == KICK, "R3 kick length", hicnt, KICK);
    if (d < LIST) begin
      for (int i = 0; i < d; i++) begin
        if (drv_low || drv_high) relbad++;
        step();
      end
      pin = 1'b0;
      for (int i = 0; i < n; i++) step();
      pin = 1'b1;
    end
    for (int i = 0; i < PMAX + LIST + 4; i++) begin
      if (drv_low || drv_high) relbad++;
      step();
    end
    chk(relbad == 0, "R3/R8 no drive after kick", relbad, 0);
    chk(overlap == 0, "R4 drive overlap", overlap, 0);
    if (exp_done) begin
      chk(ndone == 1 && nto == 0, "R6 done once", ndone * 10 + nto, 10);
      chk(lastw == n, "R6 width", lastw, n);
      chk(int'(width) == n, "R6 width held", int'(width), n);
    end else begin
      chk(nto == 1 && ndone == 0, (d >= LIST) ? "R5 silent timeout" : "R7 long pulse timeout",
          nto * 10 + ndone, 10);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!drv_low && !drv_high, "R1 drives after reset", {drv_low, drv_high}, 0);
    chk(!done && !tmo, "R1 flags after reset", {done, tmo}, 0);
    chk(width == '0, "R1 width after reset", int'(width), 0);
    for (int d = 0; d <= LIST; d++)
      for (int n = 1; n <= PMAX + 1; n++)
        run_seq(d, n, ((d + n) % 2) == 0);
    // R9: restart after completion works with a fresh sequence
    run_seq(0, 4, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule